// File: doc/BRIEF.md
# Serial-to-Parallel Deserializer with Bit Slip

This block gathers a serial bit stream into 8-bit parallel words. It runs in one of two rates, chosen by a static mode pin. In full-rate mode one serial bit enters on every rising clock edge. In dual-rate mode two bits enter per clock, presented as a 2-bit lane pair: lane 0 is the earlier bit, lane 1 the later one. A select pin chooses between two serial sources, so a loopback path can be switched in for test.

Each finished word leaves on a one-cycle valid strobe. A framing clock rises with every new word and marks the word period. A slip input drops a single serial bit, which moves the word boundary by one position so that a receiver can align to byte boundaries.

The word output is a stream with a valid strobe and no ready. A serial line cannot be stalled, so there is no back-pressure. The consumer must take `word_q` in the cycle that `word_valid` is high. After that cycle the word stays on `word_q` until the next word replaces it.

Top module: `bitslip_deser`

## Requirements
- R1: While `arst` is high, `word_q`, `word_valid` and `frame_clk` are 0, without waiting for a clock edge. After `arst` falls, the first bit is captured on the second enabled rising edge.
- R2: Within a word, the first bit accepted goes to `word_q[0]`, the next to `word_q[1]`, and so on up to `word_q[7]`. In dual-rate mode, lane bit 0 is accepted before lane bit 1.
- R3: When `sel_b` is 1 the bits come from `src_b`; when it is 0 they come from `src_a`.
- R4: With `dual_rate` = 0, each enabled edge takes only lane bit 0, and lane bit 1 has no effect. Without a slip, a word completes every 8 enabled edges.
- R5: With `dual_rate` = 1, each enabled edge takes both lane bits, and a word completes every 4 enabled edges.
- R6: A word appears on `word_q`, with `word_valid` high, 5 enabled edges (full rate) or 3 enabled edges (dual rate) after the edge that captured its last bit. Without a slip, that is 12 or 6 enabled edges after the edge that captured its first bit.
- R7: `word_valid` is high for exactly one cycle per word. `word_q` changes only in a cycle where `word_valid` is high.
- R8: `frame_clk` goes high together with each `word_valid`. It stays high for 4 (full rate) or 2 (dual rate) enabled edges, then stays low until the next word.
- R9: When `slip` is sampled high on 3 (full rate) or 2 (dual rate) consecutive enabled edges, the first bit offered on the next capture edge is discarded. That bit is lane bit 0.
- R10: A slip pulse longer than the minimum still discards only one bit, and a shorter pulse discards none. A second discard needs `slip` to be sampled low first.
- R11: An edge with `clk_en` low captures nothing and advances no counter. On that edge `word_q` and `frame_clk` hold and `word_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst | input | 1 | Asynchronous reset, active high |
| clk_en | input | 1 | Synchronous enable; low freezes the block |
| dual_rate | input | 1 | 0: one bit per edge, 1: two bits per edge |
| sel_b | input | 1 | Source select: 1 picks `src_b`, 0 picks `src_a` |
| src_a | input | 2 | Serial source A, lane 0 earlier bit |
| src_b | input | 2 | Serial source B, lane 0 earlier bit |
| slip | input | 1 | Bit-slip request (pulse-width qualified) |
| word_q | output | 8 | Parallel word |
| word_valid | output | 1 | One-cycle strobe for a new word |
| frame_clk | output | 1 | Word-framing clock |

## Verification
Each word is due a fixed count of enabled edges after the edge that captured its last bit: 5 edges at full rate, 3 at dual rate. The framing clock then stays high for half a word period. The bench counts enabled edges only, and it records the word it expects under the edge number where that word is due. Edges with the enable low move no schedule, slips lengthen a word only by the discarded bit, and every output is compared at the falling edge after each rising edge. In that way each result is checked in the exact cycle it is due.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  localparam int unsigned LANES = 2;
  typedef logic [LANES-1:0] lane_t;

  function automatic int unsigned by_rate(input logic dual, input int unsigned full_v,
                                          input int unsigned dual_v);
    return dual ? dual_v : full_v;
  endfunction
endpackage

// File: rtl/bsd_src_sel.sv
module bsd_src_sel
  import bsd_pkg::*;
(
  input  logic  sel_b,
  input  logic  dual_rate,
  input  lane_t src_a,
  input  lane_t src_b,
  output lane_t bits,
  output lane_t use_lane
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign bits[l] = sel_b ? src_b[l] : src_a[l];
    if (l == 0) begin : g_first
      assign use_lane[l] = 1'b1;
    end else begin : g_extra
      assign use_lane[l] = dual_rate;
    end
  end
endmodule

// File: rtl/bsd_slip_ctl.sv
module bsd_slip_ctl #(
  parameter int unsigned MIN_FULL = 3,
  parameter int unsigned MIN_DUAL = 2
) (
  input  logic clk,
  input  logic arst,
  input  logic en,
  input  logic dual_rate,
  input  logic slip,
  output logic fire
);
  localparam int unsigned MAXW = (MIN_FULL > MIN_DUAL) ? MIN_FULL : MIN_DUAL;
  localparam int unsigned HW   = $clog2(MAXW + 1);

  logic [HW-1:0] high_cnt;
  logic          spent;
  logic          reach;

  // reach: this sample of slip is the one that completes the minimum width
  assign reach = (int'(high_cnt) + 1) >= int'(bsd_pkg::by_rate(dual_rate, MIN_FULL, MIN_DUAL));
  assign fire  = en && slip && !spent && reach;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      high_cnt <= '0;
      spent    <= 1'b0;
    end else if (en) begin
      if (!slip) begin
        high_cnt <= '0;
        spent    <= 1'b0;
      end else if (!spent) begin
        if (reach) spent <= 1'b1;
        else       high_cnt <= high_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bsd_assembler.sv
module bsd_assembler
  import bsd_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         arst,
  input  logic         en,
  input  lane_t        bits,
  input  lane_t        use_lane,
  input  logic         fire,
  output logic         cmp,
  output logic [W-1:0] cmp_word
);
  localparam int unsigned CW = $clog2(W);

  logic          armed;
  logic          skip, skip_n;
  logic [CW-1:0] pos, pos_n;
  logic [W-1:0]  acc, acc_n;
  logic          capture;

  assign capture = en && armed;

  // Lanes are consumed in order; the bit position counter carries any odd
  // offset left by a slip from one edge to the next.
  always_comb begin
    pos_n    = pos;
    acc_n    = acc;
    skip_n   = skip;
    cmp      = 1'b0;
    cmp_word = acc;
    for (int l = 0; l < LANES; l++) begin
      if (capture && use_lane[l]) begin
        if (skip_n) begin
          skip_n = 1'b0;
        end else begin
          acc_n[pos_n] = bits[l];
          if (pos_n == CW'(W - 1)) begin
            cmp      = 1'b1;
            cmp_word = acc_n;
            pos_n    = '0;
          end else begin
            pos_n = pos_n + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      armed <= 1'b0;
      skip  <= 1'b0;
      pos   <= '0;
      acc   <= '0;
    end else if (en) begin
      armed <= 1'b1;
      skip  <= skip_n | fire;
      pos   <= pos_n;
      acc   <= acc_n;
    end
  end
endmodule

// File: rtl/bsd_framer.sv
module bsd_framer #(
  parameter int unsigned W        = 8,
  parameter int unsigned GAP_FULL = 5,
  parameter int unsigned GAP_DUAL = 3
) (
  input  logic         clk,
  input  logic         arst,
  input  logic         en,
  input  logic         dual_rate,
  input  logic         cmp,
  input  logic [W-1:0] cmp_word,
  output logic [W-1:0] word_q,
  output logic         word_valid,
  output logic         frame_clk
);
  localparam int unsigned GMAX  = (GAP_FULL > GAP_DUAL) ? GAP_FULL : GAP_DUAL;
  localparam int unsigned DW    = $clog2(GMAX + 1);
  localparam int unsigned FW    = $clog2(2 * W + 1);
  localparam logic [FW-1:0] FMAX = {FW{1'b1}};

  logic [DW-1:0] due;
  logic [W-1:0]  held;
  logic [FW-1:0] phase, phase_nx;
  logic          load;
  int unsigned   half;

  assign load     = en && (due == DW'(1));
  assign half     = bsd_pkg::by_rate(dual_rate, W / 2, W / 4);
  assign phase_nx = (phase == FMAX) ? FMAX : phase + 1'b1;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      due        <= '0;
      held       <= '0;
      phase      <= FMAX;
      word_q     <= '0;
      word_valid <= 1'b0;
      frame_clk  <= 1'b0;
    end else if (en) begin
      if (cmp) begin
        held <= cmp_word;
        due  <= DW'(bsd_pkg::by_rate(dual_rate, GAP_FULL, GAP_DUAL));
      end else if (due != '0) begin
        due <= due - 1'b1;
      end
      word_valid <= load;
      if (load) begin
        word_q    <= held;
        phase     <= '0;
        frame_clk <= 1'b1;
      end else begin
        phase     <= phase_nx;
        frame_clk <= int'(phase_nx) < int'(half);
      end
    end else begin
      word_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bitslip_deser.sv
module bitslip_deser #(
  parameter int unsigned W         = 8,
  parameter int unsigned SLIP_FULL = 3,
  parameter int unsigned SLIP_DUAL = 2,
  parameter int unsigned LAT_FULL  = 12,
  parameter int unsigned LAT_DUAL  = 6
) (
  input  logic         clk,
  input  logic         arst,
  input  logic         clk_en,
  input  logic         dual_rate,
  input  logic         sel_b,
  input  logic [1:0]   src_a,
  input  logic [1:0]   src_b,
  input  logic         slip,
  output logic [W-1:0] word_q,
  output logic         word_valid,
  output logic         frame_clk
);
  // wait after the last bit = latency minus the edges spent gathering a word
  localparam int unsigned GAP_FULL = LAT_FULL - (W - 1);
  localparam int unsigned GAP_DUAL = LAT_DUAL - (W / 2 - 1);

  bsd_pkg::lane_t bits, use_lane;
  logic           fire, cmp;
  logic [W-1:0]   cmp_word;

  bsd_src_sel u_sel (
    .sel_b(sel_b), .dual_rate(dual_rate), .src_a(src_a), .src_b(src_b),
    .bits(bits), .use_lane(use_lane)
  );

  bsd_slip_ctl #(.MIN_FULL(SLIP_FULL), .MIN_DUAL(SLIP_DUAL)) u_slip (
    .clk(clk), .arst(arst), .en(clk_en), .dual_rate(dual_rate), .slip(slip), .fire(fire)
  );

  bsd_assembler #(.W(W)) u_asm (
    .clk(clk), .arst(arst), .en(clk_en), .bits(bits), .use_lane(use_lane),
    .fire(fire), .cmp(cmp), .cmp_word(cmp_word)
  );

  bsd_framer #(.W(W), .GAP_FULL(GAP_FULL), .GAP_DUAL(GAP_DUAL)) u_frm (
    .clk(clk), .arst(arst), .en(clk_en), .dual_rate(dual_rate), .cmp(cmp),
    .cmp_word(cmp_word), .word_q(word_q), .word_valid(word_valid), .frame_clk(frame_clk)
  );
endmodule

// File: rtl/bsd_checker.sv
module bsd_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         arst,
  input logic         clk_en,
  input logic [W-1:0] word_q,
  input logic         word_valid,
  input logic         frame_clk
);
  // R1: outputs cleared while reset is held
  a_r1_reset_clear: assert property (@(posedge clk)
    arst |-> (word_q == '0 && !word_valid && !frame_clk));

  // R7: the strobe never lasts two cycles
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (arst)
    word_valid |=> !word_valid);

  // R7: the word only changes alongside the strobe
  a_r7_word_hold: assert property (@(posedge clk) disable iff (arst)
    !word_valid |-> $stable(word_q));

  // R8: framing clock is high whenever a word is delivered
  a_r8_frame_with_word: assert property (@(posedge clk) disable iff (arst)
    word_valid |-> frame_clk);

  // R11: a disabled edge freezes the outputs and raises no strobe
  a_r11_freeze: assert property (@(posedge clk) disable iff (arst)
    !clk_en |=> ($stable(word_q) && $stable(frame_clk) && !word_valid));
endmodule

bind bitslip_deser bsd_checker #(.W(W)) u_chk (
  .clk(clk), .arst(arst), .clk_en(clk_en), .word_q(word_q),
  .word_valid(word_valid), .frame_clk(frame_clk)
);

// File: tb/bitslip_deser_test.sv
module bitslip_deser_test;
  logic       clk = 1'b0;
  logic       arst = 1'b1;
  logic       clk_en = 1'b1;
  logic       dual_rate = 1'b0;
  logic       sel_b = 1'b0;
  logic [1:0] src_a = 2'b00;
  logic [1:0] src_b = 2'b00;
  logic       slip = 1'b0;
  logic [7:0] word_q;
  logic       word_valid;
  logic       frame_clk;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [7:0] sched_w [0:1023];
  bit         sched_v [0:1023];

  always #5 clk = ~clk;

  bitslip_deser uut (
    .clk(clk), .arst(arst), .clk_en(clk_en), .dual_rate(dual_rate), .sel_b(sel_b),
    .src_a(src_a), .src_b(src_b), .slip(slip), .word_q(word_q),
    .word_valid(word_valid), .frame_clk(frame_clk)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic sbit(input int seed, input int i);
    int v;
    v = i * seed + (i >> 2) * 13 + (i * i) % 7 + seed;
    return v[1] ^ v[4];
  endfunction

  task automatic do_reset();
    @(negedge clk);
    arst = 1'b1; clk_en = 1'b1; slip = 1'b0; src_a = 2'b00; src_b = 2'b00;
    #1;
    chk(word_q == 8'h00 && !word_valid && !frame_clk, "R1", "async clear",
        {word_q, word_valid, frame_clk}, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(word_q == 8'h00 && !word_valid && !frame_clk, "R1", "held in reset",
        {word_q, word_valid, frame_clk}, 0);
    arst = 1'b0;
  endtask

  task automatic run(input bit dual, input bit sel, input int seed,
                     input int sa, input int sl, input int sb, input int sbl,
                     input int ga, input int gl, input int ne, input string tag);
    int ecnt = 0, nacc = 0, hc = 0, last = 0;
    int minw, dly, half;
    bit fired = 0, dp = 0, loaded = 0, ev, ef, en_i, sy_i;
    logic [7:0] acc = 0, eq = 0;
    logic r0, r1;
    minw = dual ? 2 : 3;
    dly  = dual ? 3 : 5;
    half = dual ? 2 : 4;
    for (int k = 0; k < 1024; k++) begin
      sched_v[k] = 1'b0;
      sched_w[k] = 8'h00;
    end
    dual_rate = dual;
    sel_b = sel;
    do_reset();
    for (int e = 1; e <= ne; e++) begin
      r0 = sbit(seed, 2 * e);
      r1 = sbit(seed, 2 * e + 1);
      en_i = !(e >= ga && e < ga + gl);
      sy_i = (e >= sa && e < sa + sl) || (e >= sb && e < sb + sbl);
      clk_en = en_i;
      slip = sy_i;
      if (sel) begin src_b = {r1, r0}; src_a = ~{r1, r0}; end
      else     begin src_a = {r1, r0}; src_b = ~{r1, r0}; end
      @(posedge clk);
      ev = 1'b0;
      if (en_i) begin
        ecnt++;
        if (ecnt >= 2) begin
          for (int l = 0; l < (dual ? 2 : 1); l++) begin
            if (dp) dp = 1'b0;
            else begin
              acc[nacc] = (l == 0) ? r0 : r1;
              nacc++;
              if (nacc == 8) begin
                sched_w[ecnt + dly] = acc;
                sched_v[ecnt + dly] = 1'b1;
                nacc = 0;
              end
            end
          end
        end
        if (!sy_i) begin hc = 0; fired = 1'b0; end
        else if (!fired) begin
          hc++;
          if (hc >= minw) begin dp = 1'b1; fired = 1'b1; end
        end
        if (sched_v[ecnt]) begin
          eq = sched_w[ecnt]; ev = 1'b1; loaded = 1'b1; last = ecnt;
        end
      end
      ef = loaded && ((ecnt - last) < half);
      @(negedge clk);
      chk(word_valid == ev, {tag, " R6 R7"}, "word_valid", word_valid, ev);
      chk(word_q == eq, {tag, " R2 R6"}, "word_q", word_q, eq);
      chk(frame_clk == ef, {tag, " R8"}, "frame_clk", frame_clk, ef);
    end
  endtask

  initial begin
    run(1'b0, 1'b0, 3, 0, 0, 0, 0, 0, 0, 70, "R1 R3 R4");
    run(1'b0, 1'b1, 5, 0, 0, 0, 0, 0, 0, 60, "R3 R4");
    run(1'b1, 1'b0, 7, 0, 0, 0, 0, 0, 0, 50, "R3 R5");
    run(1'b1, 1'b1, 9, 0, 0, 0, 0, 0, 0, 50, "R3 R5");
    for (int w = 1; w <= 5; w++)
      run(1'b0, w[0], 11 + w, 20, w, 45, 3, 0, 0, 90, "R9 R10 full");
    for (int w = 1; w <= 4; w++)
      run(1'b1, w[0], 17 + w, 12, w, 25, 2, 0, 0, 60, "R9 R10 dual");
    run(1'b1, 1'b0, 23, 12, 2, 14, 2, 0, 0, 50, "R10 back-to-back");
    run(1'b0, 1'b0, 27, 0, 0, 0, 0, 17, 3, 70, "R11 full");
    run(1'b1, 1'b1, 29, 0, 0, 0, 0, 9, 2, 50, "R11 dual");
    run(1'b1, 1'b0, 31, 7, 2, 0, 0, 20, 4, 60, "R9 R11 dual");
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule